// File: doc/BRIEF.md
# Packed FP32 Predicate Compare Unit

The unit compares up to sixteen pairs of IEEE-754 single-precision values at once, one pair in each 32-bit lane. A 5-bit predicate code selects one of 32 relations. Each relation combines a base test (equal, less, less-or-equal, unordered and their complements) with a fixed result for NaN operands and a quiet or signaling treatment of quiet NaNs. In the legacy predicate mode only the low three code bits are decoded.

The unit has two output formats. In lane-mask mode each active lane returns a full 32-bit word that is all ones or all zeros. In bit-mask mode each active lane returns one bit. In bit-mask mode a zeroing write-enable mask can be applied, and lane 0 of the second operand can be broadcast to every lane. The operation width selects 4, 8 or 16 active lanes. Lanes above that count return zero. Two sticky flags collect invalid-operation and denormal-input events over the active, unmasked lanes until they are cleared.

Results and flags are registered and appear one cycle after the input strobe. They hold their value between strobes.

Top module: `fp32_pcmp`

## Requirements
- R1: Non-NaN values are ordered by numeric value. +0 and -0 compare equal, denormals order as their true values, and infinities are the extremes. A value is a NaN when its exponent is 255 and its fraction is nonzero.
- R2: For code c in 0..15 the lane is true when the relation of the pair is in this set: 0 {eq}, 1 {lt}, 2 {lt,eq}, 3 {un}, 4 {lt,gt,un}, 5 {eq,gt,un}, 6 {gt,un}, 7 {lt,eq,gt}, 8 {eq,un}, 9 {lt,un}, 10 {lt,eq,un}, 11 {}, 12 {lt,gt}, 13 {gt,eq}, 14 {gt}, 15 all. Here un means at least one operand is a NaN.
- R3: Code c in 16..31 gives the same result as code c-16.
- R4: With legacy_i=1 only pred_i[2:0] is decoded and pred_i[4:3] are ignored. With legacy_i=0 all five bits are decoded.
- R5: In lane-mask mode (bitmask_i=0), lane j of lane_o is 0xFFFFFFFF when j is active and the relation is true, and 0x00000000 otherwise. bits_o is zero, and wmask_i, mask_en_i and bcast_i have no effect.
- R6: In bit-mask mode (bitmask_i=1), bits_o[j] is 1 when lane j is active, unmasked and the relation is true. lane_o is zero. size_i selects the active lane count: 0 gives 4 lanes, 1 gives 8, 2 or 3 gives 16.
- R7: In bit-mask mode with mask_en_i=1, a lane whose wmask_i bit is 0 yields 0 and contributes no flags.
- R8: In bit-mask mode with bcast_i=1, every lane compares its op_a_i lane against op_b_i[31:0].
- R9: An operation raises invalid when an active, unmasked lane has a signaling NaN operand (fraction bit 22 clear). It also raises invalid when such a lane has a quiet NaN operand and the code is signaling. The signaling codes are 1, 2, 5, 6, 9, 10, 13, 14, 16, 19, 20, 23, 24, 27, 28 and 31.
- R10: An operation raises denormal when an active, unmasked lane has an operand with exponent 0 and a nonzero fraction.
- R11: invalid_o and denorm_o are sticky. flag_clr_i wipes the old value, and flags from an operation in the same cycle are still recorded.
- R12: valid_o follows valid_i by one cycle, and lane_o and bits_o take new values one cycle after valid_i. Without valid_i they hold their value. All outputs are zero after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operation strobe |
| op_a_i | input | 512 | First operand, lane j in bits 32j+31:32j |
| op_b_i | input | 512 | Second operand, same layout |
| pred_i | input | 5 | Predicate code |
| legacy_i | input | 1 | Decode only pred_i[2:0] |
| bitmask_i | input | 1 | 1 selects bit-mask output, 0 selects lane-mask output |
| size_i | input | 2 | Active lanes: 0 gives 4, 1 gives 8, 2 or 3 gives 16 |
| mask_en_i | input | 1 | Apply wmask_i (bit-mask mode only) |
| wmask_i | input | 16 | Per-lane write enable |
| bcast_i | input | 1 | Broadcast op_b_i lane 0 (bit-mask mode only) |
| flag_clr_i | input | 1 | Clear the sticky flags |
| valid_o | output | 1 | Result strobe |
| lane_o | output | 512 | Lane-mask result |
| bits_o | output | 16 | Bit-mask result |
| invalid_o | output | 1 | Sticky invalid flag |
| denorm_o | output | 1 | Sticky denormal flag |

## Verification
Several properties are checked by assertions on every cycle. Each lane comparison resolves to exactly one relation. A lane-mask word is never a mixed pattern. The idle format and the inactive lanes stay zero. The strobe is delayed by one cycle, results hold between strobes, and the flags are sticky and cleared correctly. Only the bench scenarios can show that each of the 32 codes selects the right relation set, that NaN, zero and denormal operands order correctly, and that masking, broadcast, legacy decoding and the flag conditions give the right values. The bench does this by comparing every cycle against an independent model.

// File: rtl/fp32_pcmp_pkg.sv
package fp32_pcmp_pkg;
  localparam int FP_W = 32;

  typedef struct packed {
    logic lt;
    logic eq;
    logic gt;
    logic un;
  } rel_t;

  typedef struct packed {
    logic nan;
    logic snan;
    logic den;
    logic zero;
  } fcls_t;

  function automatic fcls_t classify(logic [FP_W-1:0] x);
    fcls_t c;
    logic exp_max, exp_min, frac_nz;
    exp_max = &x[30:23];
    exp_min = ~|x[30:23];
    frac_nz = |x[22:0];
    c.nan  = exp_max & frac_nz;
    c.snan = exp_max & frac_nz & ~x[22];
    c.den  = exp_min & frac_nz;
    c.zero = exp_min & ~frac_nz;
    return c;
  endfunction

  // relations that make a base code (low four bits) true
  function automatic rel_t pred_set(logic [3:0] c);
    rel_t s;
    unique case (c)
      4'd0:  s = 4'b0100;
      4'd1:  s = 4'b1000;
      4'd2:  s = 4'b1100;
      4'd3:  s = 4'b0001;
      4'd4:  s = 4'b1011;
      4'd5:  s = 4'b0111;
      4'd6:  s = 4'b0011;
      4'd7:  s = 4'b1110;
      4'd8:  s = 4'b0101;
      4'd9:  s = 4'b1001;
      4'd10: s = 4'b1101;
      4'd11: s = 4'b0000;
      4'd12: s = 4'b1010;
      4'd13: s = 4'b0110;
      4'd14: s = 4'b0010;
      default: s = 4'b1111;
    endcase
    return s;
  endfunction

  // quiet NaN raises invalid for these codes; bit 4 flips the class
  function automatic logic pred_sig(logic [4:0] c);
    return ((c[1:0] == 2'd1) || (c[1:0] == 2'd2)) ^ c[4];
  endfunction
endpackage

// File: rtl/fp32_pcmp_lane.sv
module fp32_pcmp_lane
  import fp32_pcmp_pkg::*;
(
  input  logic [FP_W-1:0] a_i,
  input  logic [FP_W-1:0] b_i,
  input  logic [4:0]      code_i,
  output logic            hit_o,
  output logic            inv_o,
  output logic            den_o
);
  fcls_t ca, cb;
  rel_t  rel;
  logic  mag_lt, mag_gt;

  assign ca = classify(a_i);
  assign cb = classify(b_i);
  assign mag_lt = a_i[30:0] < b_i[30:0];
  assign mag_gt = a_i[30:0] > b_i[30:0];

  always_comb begin
    rel.un = ca.nan | cb.nan;
    rel.eq = ~rel.un & ((a_i == b_i) | (ca.zero & cb.zero));
    if (rel.un || rel.eq) begin
      rel.lt = 1'b0;
    end else if (a_i[31] != b_i[31]) begin
      rel.lt = a_i[31];
    end else begin
      rel.lt = a_i[31] ? mag_gt : mag_lt;
    end
    rel.gt = ~rel.un & ~rel.eq & ~rel.lt;
  end

  assign hit_o = |(rel & pred_set(code_i[3:0]));
  assign inv_o = ca.snan | cb.snan | ((ca.nan | cb.nan) & pred_sig(code_i));
  assign den_o = ca.den | cb.den;

  // R1: exactly one relation per pair
  always_comb begin
    a_r1_one_relation: assert ($onehot({rel.lt, rel.eq, rel.gt, rel.un}));
  end
endmodule

// File: rtl/fp32_pcmp_ctrl.sv
module fp32_pcmp_ctrl #(
  parameter int LANES = 16
) (
  input  logic [1:0]       size_i,
  input  logic             bitmask_i,
  input  logic             mask_en_i,
  input  logic [LANES-1:0] wmask_i,
  output logic [LANES-1:0] act_o,
  output logic [LANES-1:0] use_o
);
  int unsigned cnt;
  logic        masking;

  assign cnt     = (size_i == 2'd0) ? 4 : (size_i == 2'd1) ? 8 : 16;
  assign masking = bitmask_i & mask_en_i;

  for (genvar j = 0; j < LANES; j++) begin : g_act
    assign act_o[j] = (j < cnt);
    assign use_o[j] = act_o[j] & (~masking | wmask_i[j]);
  end
endmodule

// File: rtl/fp32_pcmp.sv
module fp32_pcmp
  import fp32_pcmp_pkg::*;
#(
  parameter int LANES = 16,
  localparam int VW = LANES * FP_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic [VW-1:0]    op_a_i,
  input  logic [VW-1:0]    op_b_i,
  input  logic [4:0]       pred_i,
  input  logic             legacy_i,
  input  logic             bitmask_i,
  input  logic [1:0]       size_i,
  input  logic             mask_en_i,
  input  logic [LANES-1:0] wmask_i,
  input  logic             bcast_i,
  input  logic             flag_clr_i,
  output logic             valid_o,
  output logic [VW-1:0]    lane_o,
  output logic [LANES-1:0] bits_o,
  output logic             invalid_o,
  output logic             denorm_o
);
  logic [4:0]       code;
  logic             bsel;
  logic [LANES-1:0] act, use_l, hit_v, inv_v, den_v;
  logic [VW-1:0]    lane_d, lane_q;
  logic [LANES-1:0] bits_d, bits_q, act_q;
  logic             inv_any, den_any;
  logic             valid_q, mode_q, inv_q, den_q;

  assign code = legacy_i ? {2'b00, pred_i[2:0]} : pred_i;
  assign bsel = bitmask_i & bcast_i;

  fp32_pcmp_ctrl #(.LANES(LANES)) u_ctrl (
    .size_i   (size_i),
    .bitmask_i(bitmask_i),
    .mask_en_i(mask_en_i),
    .wmask_i  (wmask_i),
    .act_o    (act),
    .use_o    (use_l)
  );

  for (genvar j = 0; j < LANES; j++) begin : g_lane
    logic [FP_W-1:0] b_lane;
    assign b_lane = bsel ? op_b_i[FP_W-1:0] : op_b_i[j*FP_W +: FP_W];
    fp32_pcmp_lane u_lane (
      .a_i   (op_a_i[j*FP_W +: FP_W]),
      .b_i   (b_lane),
      .code_i(code),
      .hit_o (hit_v[j]),
      .inv_o (inv_v[j]),
      .den_o (den_v[j])
    );
    assign lane_d[j*FP_W +: FP_W] = {FP_W{~bitmask_i & act[j] & hit_v[j]}};
    assign bits_d[j] = bitmask_i & use_l[j] & hit_v[j];
  end

  assign inv_any = |(use_l & inv_v);
  assign den_any = |(use_l & den_v);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      lane_q  <= '0;
      bits_q  <= '0;
      act_q   <= '0;
      mode_q  <= 1'b0;
      inv_q   <= 1'b0;
      den_q   <= 1'b0;
    end else begin
      valid_q <= valid_i;
      if (valid_i) begin
        lane_q <= lane_d;
        bits_q <= bits_d;
        act_q  <= act;
        mode_q <= bitmask_i;
      end
      inv_q <= (inv_q & ~flag_clr_i) | (valid_i & inv_any);
      den_q <= (den_q & ~flag_clr_i) | (valid_i & den_any);
    end
  end

  assign valid_o   = valid_q;
  assign lane_o    = lane_q;
  assign bits_o    = bits_q;
  assign invalid_o = inv_q;
  assign denorm_o  = den_q;

  a_r12_valid_delay: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);
  a_r12_no_spurious: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o);
  a_r12_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> ($stable(lane_o) && $stable(bits_o)));
  a_r5_bits_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !mode_q) |-> (bits_o == '0));
  a_r6_lane_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && mode_q) |-> ((lane_o == '0) && ((bits_o & ~act_q) == '0)));
  a_r11_inv_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (invalid_o && !flag_clr_i) |=> invalid_o);
  a_r11_den_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (denorm_o && !flag_clr_i) |=> denorm_o);
  a_r11_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_clr_i && !valid_i) |=> (!invalid_o && !denorm_o));

  for (genvar j = 0; j < LANES; j++) begin : g_chk
    a_r5_lane_word: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (valid_o && !mode_q) |->
        ((lane_o[j*FP_W +: FP_W] == '0) || (lane_o[j*FP_W +: FP_W] == '1)));
  end
endmodule

// File: tb/fp32_pcmp_bench.sv
module fp32_pcmp_bench;
  localparam int L = 16;
  localparam int VW = L * 32;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic valid_i = 1'b0;
  logic [VW-1:0] op_a_i = '0, op_b_i = '0;
  logic [4:0] pred_i = '0;
  logic legacy_i = 1'b0, bitmask_i = 1'b0, mask_en_i = 1'b0, bcast_i = 1'b0, flag_clr_i = 1'b0;
  logic [1:0] size_i = '0;
  logic [L-1:0] wmask_i = '0;
  logic valid_o, invalid_o, denorm_o;
  logic [VW-1:0] lane_o;
  logic [L-1:0] bits_o;

  always #5 clk = ~clk;

  fp32_pcmp u_fp32_pcmp (
    .clk_i(clk), .rst_ni(rst_ni), .valid_i(valid_i), .op_a_i(op_a_i), .op_b_i(op_b_i),
    .pred_i(pred_i), .legacy_i(legacy_i), .bitmask_i(bitmask_i), .size_i(size_i),
    .mask_en_i(mask_en_i), .wmask_i(wmask_i), .bcast_i(bcast_i), .flag_clr_i(flag_clr_i),
    .valid_o(valid_o), .lane_o(lane_o), .bits_o(bits_o), .invalid_o(invalid_o),
    .denorm_o(denorm_o)
  );

  int total = 0, bad = 0;
  string tag = "R12";
  logic e_valid = 1'b0, e_inv = 1'b0, e_den = 1'b0;
  logic [VW-1:0] e_lane = '0;
  logic [L-1:0] e_bits = '0;

  function automatic bit is_nan(logic [31:0] x);
    return (x[30:23] == 8'hFF) && (x[22:0] != 0);
  endfunction
  function automatic bit is_snan(logic [31:0] x);
    return is_nan(x) && !x[22];
  endfunction
  function automatic bit is_den(logic [31:0] x);
    return (x[30:23] == 8'h00) && (x[22:0] != 0);
  endfunction
  function automatic longint key(logic [31:0] x);
    longint m = longint'(x[30:0]);
    return x[31] ? -m : m;
  endfunction
  function automatic bit sig_code(int c);
    case (c)
      1, 2, 5, 6, 9, 10, 13, 14, 16, 19, 20, 23, 24, 27, 28, 31: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction
  function automatic bit relate(int c, logic [31:0] a, logic [31:0] b);
    bit u = is_nan(a) || is_nan(b);
    bit lt = !u && key(a) < key(b);
    bit gt = !u && key(a) > key(b);
    bit eq = !u && !lt && !gt;
    case (c % 16)
      0: return eq;
      1: return lt;
      2: return lt || eq;
      3: return u;
      4: return !eq;
      5: return !lt;
      6: return !(lt || eq);
      7: return !u;
      8: return eq || u;
      9: return lt || u;
      10: return !gt;
      11: return 1'b0;
      12: return lt || gt;
      13: return gt || eq;
      14: return gt;
      default: return 1'b1;
    endcase
  endfunction

  function automatic logic [31:0] pick();
    case ($urandom % 16)
      0: return 32'h0000_0000;
      1: return 32'h8000_0000;
      2: return 32'h3F80_0000;
      3: return 32'hBF80_0000;
      4: return 32'h4000_0000;
      5: return 32'h0000_0001;
      6: return 32'h8000_0003;
      7: return 32'h7F80_0000;
      8: return 32'hFF80_0000;
      9: return 32'h7FC0_0000;
      10: return 32'h7F80_0001;
      11: return 32'h7F7F_FFFF;
      12: return 32'h3F80_0000;
      13: return 32'hC000_0000;
      default: return $urandom;
    endcase
  endfunction
  function automatic logic [VW-1:0] rvec(bit clean);
    logic [VW-1:0] v;
    for (int j = 0; j < L; j++) begin
      logic [31:0] x = pick();
      if (clean && (is_nan(x) || is_den(x))) x = 32'h4040_0000;
      v[j*32 +: 32] = x;
    end
    return v;
  endfunction

  task automatic chk(bit ok, string what, logic [VW-1:0] act, logic [VW-1:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
    end
  endtask

  task automatic compare_all();
    chk(valid_o == e_valid, "valid_o", VW'(valid_o), VW'(e_valid));
    chk(lane_o == e_lane, "lane_o", lane_o, e_lane);
    chk(bits_o == e_bits, "bits_o", VW'(bits_o), VW'(e_bits));
    chk(invalid_o == e_inv, "invalid_o (R9/R11)", VW'(invalid_o), VW'(e_inv));
    chk(denorm_o == e_den, "denorm_o (R10/R11)", VW'(denorm_o), VW'(e_den));
  endtask

  // drive one cycle after a negedge, model it, then check at the next negedge
  task automatic step(bit v, logic [VW-1:0] a, logic [VW-1:0] b, int p, bit leg,
                      bit bm, int sz, bit men, logic [L-1:0] wm, bit bc, bit clr);
    int code, cnt;
    bit inv_n = 1'b0, den_n = 1'b0;
    valid_i = v; op_a_i = a; op_b_i = b; pred_i = 5'(p); legacy_i = leg;
    bitmask_i = bm; size_i = 2'(sz); mask_en_i = men; wmask_i = wm; bcast_i = bc;
    flag_clr_i = clr;
    code = leg ? (p % 8) : (p % 32);
    cnt = (sz == 0) ? 4 : (sz == 1) ? 8 : 16;
    e_valid = v;
    if (v) begin
      e_lane = '0;
      e_bits = '0;
      for (int j = 0; j < L; j++) begin
        logic [31:0] x = a[j*32 +: 32];
        logic [31:0] y = (bm && bc) ? b[31:0] : b[j*32 +: 32];
        bit on = (j < cnt) && !(bm && men && !wm[j]);
        bit r = relate(code, x, y);
        if (!bm && j < cnt && r) e_lane[j*32 +: 32] = 32'hFFFF_FFFF;
        if (bm && on && r) e_bits[j] = 1'b1;
        if (on && (is_snan(x) || is_snan(y) || ((is_nan(x) || is_nan(y)) && sig_code(code))))
          inv_n = 1'b1;
        if (on && (is_den(x) || is_den(y))) den_n = 1'b1;
      end
    end
    e_inv = (e_inv && !clr) || inv_n;
    e_den = (e_den && !clr) || den_n;
    @(negedge clk);
    compare_all();
  endtask

  task automatic op(int p, bit leg, bit bm, int sz, bit men, logic [L-1:0] wm, bit bc, bit clr);
    step(1'b1, rvec(0), rvec(0), p, leg, bm, sz, men, wm, bc, clr);
  endtask

  bit done = 1'b0;
  initial begin
    int cyc = 0;
    while (!done && cyc < 150000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    tag = "R12";
    compare_all(); // reset state
    rst_ni = 1'b1;
    @(negedge clk);
    compare_all();

    // R1: ordering with zeros, denormals, infinities
    tag = "R1";
    for (int i = 0; i < 40; i++) op(i % 3, 0, 0, 2, 0, '0, 0, 1);
    tag = "R1";
    step(1, {L{32'h8000_0000}}, {L{32'h0000_0000}}, 0, 0, 1, 2, 0, '0, 0, 1);
    chk(bits_o == 16'hFFFF, "R1 zero eq bits", VW'(bits_o), VW'(16'hFFFF));

    // R2: base codes
    tag = "R2";
    for (int c = 0; c < 16; c++)
      for (int i = 0; i < 6; i++) op(c, 0, 0, i % 3, 0, '0, 0, i[0]);
    // R3: upper codes
    tag = "R3";
    for (int c = 16; c < 32; c++)
      for (int i = 0; i < 6; i++) op(c, 0, i[0], 2, 0, '0, 0, 1);
    // R4: legacy decoding ignores pred bits 4:3
    tag = "R4";
    for (int i = 0; i < 30; i++) op(int'($urandom % 32), 1, i[0], 2, 0, '0, 0, 1);
    for (int i = 0; i < 20; i++) op(int'($urandom % 32), 0, i[0], 1, 0, '0, 0, 1);
    // R5: lane mode, mask and broadcast have no effect
    tag = "R5";
    for (int i = 0; i < 30; i++) op(int'($urandom % 32), 0, 0, i % 4, 1, 16'(($urandom)), 1, i[0]);
    // R6: bit-mask mode, lane counts
    tag = "R6";
    for (int i = 0; i < 30; i++) op(int'($urandom % 32), 0, 1, i % 4, 0, '0, 0, 1);
    // R7: write-enable masking
    tag = "R7";
    for (int i = 0; i < 30; i++) op(int'($urandom % 32), 0, 1, i % 3, 1, 16'(($urandom)), 0, 1);
    step(1, {L{32'h7F80_0001}}, {L{32'h3F80_0000}}, 15, 0, 1, 2, 1, 16'h0000, 0, 1);
    chk(bits_o == '0 && !invalid_o, "R7 all masked", VW'({bits_o, invalid_o}), '0);
    // R8: broadcast
    tag = "R8";
    for (int i = 0; i < 30; i++) op(int'($urandom % 32), 0, 1, 2, i[0], 16'(($urandom)), 1, 1);
    // R9 / R10: flag conditions, one op at a time
    tag = "R9";
    for (int i = 0; i < 30; i++) op(int'($urandom % 32), 0, i[0], i % 3, i[1], 16'(($urandom)), 0, 1);
    step(1, {L{32'h7FC0_0000}}, {L{32'h3F80_0000}}, 0, 0, 0, 2, 0, '0, 0, 1);
    chk(!invalid_o, "R9 qnan quiet code", VW'(invalid_o), '0);
    step(1, {L{32'h7FC0_0000}}, {L{32'h3F80_0000}}, 1, 0, 0, 2, 0, '0, 0, 1);
    chk(invalid_o, "R9 qnan signaling code", VW'(invalid_o), VW'(1));
    tag = "R10";
    step(1, {L{32'h0000_0001}}, {L{32'h3F80_0000}}, 3, 0, 0, 0, 0, '0, 0, 1);
    chk(denorm_o, "R10 denormal", VW'(denorm_o), VW'(1));
    // R11: sticky accumulation and clear
    tag = "R11";
    for (int i = 0; i < 20; i++) op(int'($urandom % 32), 0, 0, 0, 0, '0, 0, 0);
    step(0, '0, '0, 0, 0, 0, 0, 0, '0, 0, 1);
    chk(!invalid_o && !denorm_o, "R11 cleared", VW'({invalid_o, denorm_o}), '0);
    // R12: idle cycles hold the results
    tag = "R12";
    for (int i = 0; i < 40; i++) begin
      if (i % 3 == 0) op(int'($urandom % 32), 0, i[0], 2, 0, '0, 0, 0);
      else step(0, rvec(0), rvec(0), int'($urandom % 32), 0, i[1], 2, 0, '0, 0, 0);
    end

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule